// File: doc/BRIEF.md
# Two-Pointer Replacement Tracker for One Cache Set

This block chooses which way of a single cache set is overwritten on a miss. It does not order every way by age. It keeps just two pointers: the way that goes next (the victim) and the way lined up after it (the next victim). All the remaining ways form an ordinary pool. Hits and misses move the pointers by fixed rules. A free-running linear feedback shift register draws a fresh next victim out of the ordinary pool whenever one is needed.

The surrounding cache logic reports each access. It sends a one-cycle hit strobe with the index of the matching way, or a one-cycle miss strobe. The tracker always presents both pointers on registered outputs, so the victim pointer is ready before a miss occurs. One cycle after a miss, the tracker also reports which way was given up. Tag compare, data storage and invalid-way selection belong to the caller.

Top module: `vnv_repl_tracker`

## Requirements
- R1: While rstN is low, and in the first cycle after it rises, victimWay is 0, nextVictimWay is 1 and replaceValid is 0.
- R2: victimWay and nextVictimWay always differ, and both are below WAYS.
- R3: After a miss, victimWay equals the nextVictimWay that was presented during the miss cycle.
- R4: After a miss, nextVictimWay differs from both pointers that were presented during the miss cycle.
- R5: replaceValid is 1 for exactly the one cycle after a miss, with replaceWay equal to the victimWay presented during the miss. In every other cycle replaceValid is 0.
- R6: After a hit whose way equals nextVictimWay, victimWay is unchanged and nextVictimWay differs from both earlier pointers.
- R7: After a hit whose way equals victimWay, victimWay takes the earlier nextVictimWay, and nextVictimWay differs from both earlier pointers.
- R8: A hit to a way that is neither pointer leaves both pointers unchanged.
- R9: hitValid and missValid are never high in the same cycle. A cycle with neither strobe leaves both pointers unchanged.
- R10: With WAYS of at least 4, a long run of misses draws at least two different ways as the next victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hitValid | input | 1 | Hit strobe for the set |
| hitWay | input | $clog2(WAYS) | Way that hit |
| missValid | input | 1 | Miss strobe for the set |
| victimWay | output | $clog2(WAYS) | Current victim pointer |
| nextVictimWay | output | $clog2(WAYS) | Current next-victim pointer |
| replaceValid | output | 1 | One-cycle report that a way was replaced |
| replaceWay | output | $clog2(WAYS) | Way replaced by the last miss |

## Verification
A hit and a miss can never arrive together. The replace report from a miss, however, is still on the outputs during the cycle in which a following hit is being applied. The bench sends a miss and, with no gap, a hit on the freshly promoted next victim. It then checks that the report lasts one cycle while the hit's pointer update lands correctly. The next victim is drawn at random, so the bench does not predict its exact value. It judges each draw against the set of ways that are eligible.

// File: rtl/vnv_pkg.sv
package vnv_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;    // victim <= next victim, next victim <= pick
    logic refreshNv;  // next victim <= pick
    logic report;     // raise replace report next cycle
  } vnvStrobes_t;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_HIT_VICTIM,
    ACC_HIT_NEXT,
    ACC_HIT_OTHER
  } accKind_t;

endpackage

// File: rtl/vnv_ctrl.sv
module vnv_ctrl
  import vnv_pkg::*;
#(
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             hitValid,
  input  logic [WAY_W-1:0] hitWay,
  input  logic             missValid,
  input  logic [WAY_W-1:0] curV,
  input  logic [WAY_W-1:0] curNv,
  output vnvStrobes_t      strobes
);

  accKind_t hitKind;

  always_comb begin
    if (!hitValid)            hitKind = ACC_NONE;
    else if (hitWay == curV)  hitKind = ACC_HIT_VICTIM;
    else if (hitWay == curNv) hitKind = ACC_HIT_NEXT;
    else                      hitKind = ACC_HIT_OTHER;
  end

  always_comb begin
    strobes = '0;
    if (missValid) begin
      strobes.advance = 1'b1;
      strobes.report  = 1'b1;
    end else begin
      unique case (hitKind)
        ACC_HIT_VICTIM: strobes.advance   = 1'b1;
        ACC_HIT_NEXT:   strobes.refreshNv = 1'b1;
        default:        strobes = '0;
      endcase
    end
  end

endmodule

// File: rtl/vnv_datapath.sv
module vnv_datapath
  import vnv_pkg::*;
#(
  parameter int              WAYS      = 4,
  parameter int              LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h01,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  vnvStrobes_t      strobes,
  output logic [WAY_W-1:0] curV,
  output logic [WAY_W-1:0] curNv,
  output logic             replaceValid,
  output logic [WAY_W-1:0] replaceWay
);

  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);
  localparam bit               POW2     = (WAYS == (1 << WAY_W));

  logic [LFSR_W-1:0] lfsr;
  logic [WAY_W-1:0]  baseWay, stepOne, pickWay;

  // Free-running Galois LFSR
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lfsr <= LFSR_SEED;
    else if (lfsr[0]) lfsr <= (lfsr >> 1) ^ LFSR_TAPS;
    else              lfsr <= lfsr >> 1;
  end

  // Fold LFSR onto the way range
  generate
    if (POW2) begin : g_mask
      assign baseWay = lfsr[WAY_W-1:0];
    end else begin : g_mod
      logic [LFSR_W-1:0] modVal;
      assign modVal  = lfsr % LFSR_W'(WAYS);
      assign baseWay = modVal[WAY_W-1:0];
    end
  endgenerate

  function automatic logic [WAY_W-1:0] skipWay(
    input logic [WAY_W-1:0] w,
    input logic [WAY_W-1:0] a,
    input logic [WAY_W-1:0] b
  );
    if (w == a || w == b) return (w == LAST_WAY) ? '0 : w + 1'b1;
    return w;
  endfunction

  // Two wrap-around steps clear both excluded ways
  assign stepOne = skipWay(baseWay, curV, curNv);
  assign pickWay = skipWay(stepOne, curV, curNv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curV         <= '0;
      curNv        <= WAY_W'(1);
      replaceValid <= 1'b0;
      replaceWay   <= '0;
    end else begin
      replaceValid <= strobes.report;
      if (strobes.report) replaceWay <= curV;
      if (strobes.advance) begin
        curV  <= curNv;
        curNv <= pickWay;
      end else if (strobes.refreshNv) begin
        curNv <= pickWay;
      end
    end
  end

endmodule

// File: rtl/vnv_repl_tracker.sv
module vnv_repl_tracker
  import vnv_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int LFSR_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hitValid,
  input  logic [WAY_W-1:0] hitWay,
  input  logic             missValid,
  output logic [WAY_W-1:0] victimWay,
  output logic [WAY_W-1:0] nextVictimWay,
  output logic             replaceValid,
  output logic [WAY_W-1:0] replaceWay
);

  vnvStrobes_t strobes;

  vnv_ctrl #(.WAYS(WAYS)) uCtrl (
    .hitValid (hitValid),
    .hitWay   (hitWay),
    .missValid(missValid),
    .curV     (victimWay),
    .curNv    (nextVictimWay),
    .strobes  (strobes)
  );

  vnv_datapath #(.WAYS(WAYS), .LFSR_W(LFSR_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .curV        (victimWay),
    .curNv       (nextVictimWay),
    .replaceValid(replaceValid),
    .replaceWay  (replaceWay)
  );

endmodule

// File: rtl/vnv_repl_checker.sv
module vnv_repl_checker #(
  parameter int WAYS   = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             hitValid,
  input logic [WAY_W-1:0] hitWay,
  input logic             missValid,
  input logic [WAY_W-1:0] victimWay,
  input logic [WAY_W-1:0] nextVictimWay,
  input logic             replaceValid,
  input logic [WAY_W-1:0] replaceWay
);

  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

  p_excl_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(hitValid && missValid));

  p_distinct_r2: assert property (@(posedge clk) disable iff (!rstN)
    victimWay != nextVictimWay && victimWay <= LAST_WAY && nextVictimWay <= LAST_WAY);

  p_miss_promote_r3: assert property (@(posedge clk) disable iff (!rstN)
    missValid |=> victimWay == $past(nextVictimWay));

  p_miss_pick_r4: assert property (@(posedge clk) disable iff (!rstN)
    missValid |=> nextVictimWay != $past(victimWay) && nextVictimWay != $past(nextVictimWay));

  p_miss_report_r5: assert property (@(posedge clk) disable iff (!rstN)
    missValid |=> replaceValid && replaceWay == $past(victimWay));

  p_no_report_r5: assert property (@(posedge clk) disable iff (!rstN)
    !missValid |=> !replaceValid);

  p_hit_next_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hitValid && hitWay == nextVictimWay) |=>
      victimWay == $past(victimWay) && nextVictimWay != $past(victimWay)
      && nextVictimWay != $past(nextVictimWay));

  p_hit_victim_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hitValid && hitWay == victimWay) |=>
      victimWay == $past(nextVictimWay) && nextVictimWay != $past(victimWay));

  p_hit_other_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hitValid && hitWay != victimWay && hitWay != nextVictimWay) |=>
      $stable(victimWay) && $stable(nextVictimWay));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!hitValid && !missValid) |=> $stable(victimWay) && $stable(nextVictimWay));

endmodule

bind vnv_repl_tracker vnv_repl_checker #(.WAYS(WAYS)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .hitValid     (hitValid),
  .hitWay       (hitWay),
  .missValid    (missValid),
  .victimWay    (victimWay),
  .nextVictimWay(nextVictimWay),
  .replaceValid (replaceValid),
  .replaceWay   (replaceWay)
);

// File: tb/tb_vnv_repl_tracker.sv
`timescale 1ns/1ps
module tb_vnv_repl_tracker;

  localparam int WAYS = 4;
  localparam int WW   = 2;
  // ops: 0 idle, 1 miss, 2 hit victim, 3 hit next victim, 4 hit other
  localparam int NOPS = 24;
  localparam logic [2:0] OPS [NOPS] = '{
    3'd1, 3'd4, 3'd2, 3'd3, 3'd0, 3'd1, 3'd1, 3'd3,
    3'd4, 3'd2, 3'd2, 3'd0, 3'd3, 3'd3, 3'd1, 3'd4,
    3'd2, 3'd1, 3'd0, 3'd3, 3'd4, 3'd1, 3'd2, 3'd1
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic hitValid = 1'b0, missValid = 1'b0;
  logic [WW-1:0] hitWay = '0;
  logic [WW-1:0] victimWay, nextVictimWay, replaceWay;
  logic replaceValid;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [WW-1:0] mV, mNv;

  always #4 clk = ~clk;

  vnv_repl_tracker #(.WAYS(WAYS)) dut (
    .clk(clk), .rstN(rstN), .hitValid(hitValid), .hitWay(hitWay),
    .missValid(missValid), .victimWay(victimWay), .nextVictimWay(nextVictimWay),
    .replaceValid(replaceValid), .replaceWay(replaceWay)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] otherWay(input logic [WW-1:0] a, input logic [WW-1:0] b);
    for (int w = 0; w < WAYS; w++)
      if (WW'(w) != a && WW'(w) != b) return WW'(w);
    return '0;
  endfunction

  task automatic checkPair();
    chk(victimWay != nextVictimWay, "R2 distinct", victimWay, nextVictimWay);
  endtask

  // Apply one op for one cycle, then check against model
  task automatic doOp(input logic [2:0] op);
    @(negedge clk);
    mV = victimWay; mNv = nextVictimWay;
    missValid = (op == 3'd1);
    hitValid  = (op >= 3'd2);
    hitWay    = (op == 3'd2) ? mV : (op == 3'd3) ? mNv : otherWay(mV, mNv);
    @(negedge clk);
    missValid = 1'b0; hitValid = 1'b0;
    case (op)
      3'd1: begin
        chk(victimWay == mNv, "R3 miss victim", victimWay, mNv);
        chk(nextVictimWay != mV && nextVictimWay != mNv, "R4 miss next", nextVictimWay, mV);
        chk(replaceValid && replaceWay == mV, "R5 report way", replaceWay, mV);
      end
      3'd2: begin
        chk(victimWay == mNv, "R7 hit victim", victimWay, mNv);
        chk(nextVictimWay != mV && nextVictimWay != mNv, "R7 hit victim next", nextVictimWay, mV);
      end
      3'd3: begin
        chk(victimWay == mV, "R6 hit next victim", victimWay, mV);
        chk(nextVictimWay != mV && nextVictimWay != mNv, "R6 hit next new", nextVictimWay, mNv);
      end
      3'd4: begin
        chk(victimWay == mV && nextVictimWay == mNv, "R8 hit other", nextVictimWay, mNv);
      end
      default: begin
        chk(victimWay == mV && nextVictimWay == mNv, "R9 idle", nextVictimWay, mNv);
      end
    endcase
    if (op != 3'd1) chk(!replaceValid, "R5 no report", replaceValid, 0);
    checkPair();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seen;
    logic [WAYS-1:0] nvMask;
    repeat (3) @(negedge clk);
    chk(victimWay == 0 && nextVictimWay == 1 && !replaceValid, "R1 in reset", nextVictimWay, 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(victimWay == 0 && nextVictimWay == 1 && !replaceValid, "R1 after reset", victimWay, 0);

    for (int i = 0; i < NOPS; i++) doOp(OPS[i]);

    // Miss then hit on the promoted next victim, back to back
    @(negedge clk);
    mV = victimWay; mNv = nextVictimWay;
    missValid = 1'b1;
    @(negedge clk);
    missValid = 1'b0;
    chk(replaceValid && replaceWay == mV, "R5 back-to-back report", replaceWay, mV);
    chk(victimWay == mNv, "R3 back-to-back", victimWay, mNv);
    mV = victimWay; mNv = nextVictimWay;
    hitValid = 1'b1; hitWay = mNv;
    @(negedge clk);
    hitValid = 1'b0;
    chk(!replaceValid, "R5 single pulse", replaceValid, 0);
    chk(victimWay == mV, "R6 back-to-back", victimWay, mV);
    chk(nextVictimWay != mV && nextVictimWay != mNv, "R6 back-to-back next", nextVictimWay, mNv);

    // Randomness over many misses
    nvMask = '0;
    for (int i = 0; i < 40; i++) begin
      doOp(3'd1);
      nvMask[nextVictimWay] = 1'b1;
    end
    seen = $countones(nvMask);
    chk(seen >= 2, "R10 spread", seen, 2);

    // Idle stretch
    for (int i = 0; i < 3; i++) doOp(3'd0);

    // Reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(victimWay == 0 && nextVictimWay == 1 && !replaceValid, "R1 mid-run reset", victimWay, 0);
    rstN = 1'b1;
    doOp(3'd4);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule